// File: doc/BRIEF.md
# Row-Granular Nonvolatile Write Combiner

This block sits between a register-bus slave and a nonvolatile array built from fixed-size rows. During one write transaction it collects each written byte into a staging area together with a per-byte modified mask, and it marks every row the transaction touched. When the transaction ends, it programs each marked row once. Each program operation merges the staged bytes with the row's present contents and rewrites the whole row. One program operation takes a fixed busy time. A saturating wear counter is kept for every row.

A mode input selects a volatile scratch copy as the target of a transaction. In that mode the bytes land directly in the scratch copy. Nothing is programmed, no busy time is spent and no wear is counted. Every program operation also refreshes the scratch copy of the row it wrote, so after a commit the two copies agree for that row. Two read ports give the contents of the scratch copy and of the nonvolatile array at the same address, and a third port gives the wear count of a chosen row. While programming is under way the block is busy and refuses new transactions.

Top module: `nvm_row_writer`

## Requirements
- R1: After reset, `busy` and `wr_start_ack` are 0, every byte on both read ports reads 0x00, and every row's wear count is 0.
- R2: A normal-mode transaction writes bytes at consecutive addresses, starting from `wr_addr` and wrapping from the last address to address 0. After it completes, the nonvolatile port and the scratch port both return the written bytes.
- R3: The bytes of a touched row that the transaction did not write keep their previous nonvolatile values. After the commit, the scratch copy of that row equals its nonvolatile row.
- R4: Each commit adds exactly one to the wear count of the committed row, whether one byte or all bytes were written. Rows that were not touched keep their counts.
- R5: When `sram_mode` is 1 at the accepted start, the written bytes update only the scratch port. The nonvolatile port and the wear counts do not change, and `busy` stays 0.
- R6: A normal transaction that touches k rows (k>0) commits them one after another in ascending row order. `busy` is high for exactly 1 + k*(BUSY_CYCLES+1) cycles, starting the cycle after the stop.
- R7: While `busy` is 1, `wr_start_ack` is 0, and the refused transaction's bytes change neither port.
- R8: A row's wear count saturates at 2^WEAR_W-1 and never wraps.
- R9: The nonvolatile contents do not change before the stop of a transaction. They change only in the cycle a row is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sram_mode | input | 1 | Scratch-only target, sampled at an accepted start |
| wr_start | input | 1 | Start of a write transaction (one-cycle pulse) |
| wr_addr | input | ADDR_W | First byte address of the transaction |
| wr_start_ack | output | 1 | Start accepted (combinational, high only when idle) |
| wr_valid | input | 1 | One data byte present this cycle |
| wr_data | input | 8 | Data byte |
| wr_stop | input | 1 | End of the transaction (one-cycle pulse) |
| busy | output | 1 | Row programming in progress |
| rd_addr | input | ADDR_W | Read address for both read ports |
| rd_data | output | 8 | Scratch copy byte at `rd_addr` |
| rd_nvm_data | output | 8 | Nonvolatile byte at `rd_addr` |
| wear_row | input | ROW_W | Row selected for the wear count |
| wear_count | output | WEAR_W | Wear count of `wear_row` |

## Verification
The assertions assume that the slave follows the transaction order. A start is a single-cycle pulse that comes only when no transaction is open, and bytes and the stop arrive only after a start was accepted. They also assume that the row count and row width are powers of two, so a byte address splits cleanly into a row and a column. The bench changes inputs only on falling edges and holds every control as a one-cycle pulse. It sends no start inside an open transaction, and it issues a refused transaction only while the block is visibly busy. In this way every stimulus stays within those assumptions.

// File: rtl/nrw_pkg.sv
package nrw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_SCAN = 2'd2,
        ST_PROG = 2'd3
    } wr_state_e;
endpackage

// File: rtl/nrw_first_set.sv
module nrw_first_set #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/nrw_row_merge.sv
module nrw_row_merge #(
    parameter int ROW_BYTES = 8
) (
    input  logic [ROW_BYTES*8-1:0] old_row,
    input  logic [ROW_BYTES*8-1:0] new_row,
    input  logic [ROW_BYTES-1:0]   keep_new,
    output logic [ROW_BYTES*8-1:0] merged
);
    for (genvar c = 0; c < ROW_BYTES; c++) begin : g_byte
        assign merged[c*8 +: 8] = keep_new[c] ? new_row[c*8 +: 8] : old_row[c*8 +: 8];
    end
endmodule

// File: rtl/nrw_sat_inc.sv
module nrw_sat_inc #(
    parameter int W = 4
) (
    input  logic [W-1:0] cnt_in,
    output logic [W-1:0] cnt_out
);
    assign cnt_out = (&cnt_in) ? cnt_in : cnt_in + W'(1);
endmodule

// File: rtl/nvm_row_writer.sv
module nvm_row_writer
    import nrw_pkg::*;
#(
    parameter int ROWS        = 8,
    parameter int ROW_BYTES   = 8,
    parameter int WEAR_W      = 4,
    parameter int BUSY_CYCLES = 4,
    localparam int DEPTH      = ROWS * ROW_BYTES,
    localparam int ADDR_W     = $clog2(DEPTH),
    localparam int ROW_W      = $clog2(ROWS),
    localparam int COL_W      = $clog2(ROW_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sram_mode,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_start_ack,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic              wr_stop,
    output logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [7:0]        rd_nvm_data,
    input  logic [ROW_W-1:0]  wear_row,
    output logic [WEAR_W-1:0] wear_count
);
    localparam int TMR_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [WEAR_W-1:0] WEAR_MAX = '1;

    typedef struct packed {
        wr_state_e         state;
        logic [ADDR_W-1:0] addr;
        logic              shadow;
        logic [ROW_W-1:0]  row;
        logic [TMR_W-1:0]  timer;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic [7:0]        nvm_d   [DEPTH];
    logic [7:0]        nvm_q   [DEPTH];
    logic [7:0]        sram_d  [DEPTH];
    logic [7:0]        sram_q  [DEPTH];
    logic [7:0]        stage_d [DEPTH];
    logic [7:0]        stage_q [DEPTH];
    logic [DEPTH-1:0]  mask_d, mask_q;
    logic [ROWS-1:0]   dirty_d, dirty_q;
    logic [WEAR_W-1:0] wear_d  [ROWS];
    logic [WEAR_W-1:0] wear_q  [ROWS];

    // Current-row views for the merge
    logic [ROW_BYTES*8-1:0] old_row, new_row, merged_row;
    logic [ROW_BYTES-1:0]   row_mask;
    logic                   row_found;
    logic [ROW_W-1:0]       next_row;
    logic [WEAR_W-1:0]      wear_next;
    logic                   commit_now;

    for (genvar c = 0; c < ROW_BYTES; c++) begin : g_row_view
        localparam logic [COL_W-1:0] CI = COL_W'(c);
        assign old_row[c*8 +: 8] = nvm_q[{ctrl_q.row, CI}];
        assign new_row[c*8 +: 8] = stage_q[{ctrl_q.row, CI}];
        assign row_mask[c]       = mask_q[{ctrl_q.row, CI}];
    end

    nrw_row_merge #(.ROW_BYTES(ROW_BYTES)) u_merge (
        .old_row  (old_row),
        .new_row  (new_row),
        .keep_new (row_mask),
        .merged   (merged_row)
    );

    nrw_first_set #(.N(ROWS), .W(ROW_W)) u_scan (
        .vec   (dirty_q),
        .found (row_found),
        .idx   (next_row)
    );

    nrw_sat_inc #(.W(WEAR_W)) u_wear_inc (
        .cnt_in  (wear_q[ctrl_q.row]),
        .cnt_out (wear_next)
    );

    assign commit_now = (ctrl_q.state == ST_PROG) && (ctrl_q.timer == '0);

    always_comb begin
        ctrl_d       = ctrl_q;
        nvm_d        = nvm_q;
        sram_d       = sram_q;
        stage_d      = stage_q;
        mask_d       = mask_q;
        dirty_d      = dirty_q;
        wear_d       = wear_q;
        wr_start_ack = 1'b0;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (wr_start) begin
                    wr_start_ack  = 1'b1;
                    ctrl_d.state  = ST_RECV;
                    ctrl_d.addr   = wr_addr;
                    ctrl_d.shadow = sram_mode;
                end
            end
            ST_RECV: begin
                if (wr_valid) begin
                    if (ctrl_q.shadow) begin
                        sram_d[ctrl_q.addr] = wr_data;
                    end else begin
                        stage_d[ctrl_q.addr] = wr_data;
                        mask_d[ctrl_q.addr]  = 1'b1;
                        dirty_d[ctrl_q.addr[ADDR_W-1:COL_W]] = 1'b1;
                    end
                    ctrl_d.addr = ctrl_q.addr + ADDR_W'(1);
                end
                if (wr_stop) begin
                    ctrl_d.state = (!ctrl_q.shadow && (|dirty_d)) ? ST_SCAN : ST_IDLE;
                end
            end
            ST_SCAN: begin
                if (row_found) begin
                    ctrl_d.row   = next_row;
                    ctrl_d.timer = TMR_W'(BUSY_CYCLES - 1);
                    ctrl_d.state = ST_PROG;
                end else begin
                    ctrl_d.state = ST_IDLE;
                end
            end
            ST_PROG: begin
                if (ctrl_q.timer == '0) begin
                    for (int c = 0; c < ROW_BYTES; c++) begin
                        nvm_d[{ctrl_q.row, COL_W'(c)}]  = merged_row[c*8 +: 8];
                        sram_d[{ctrl_q.row, COL_W'(c)}] = merged_row[c*8 +: 8];
                        mask_d[{ctrl_q.row, COL_W'(c)}] = 1'b0;
                    end
                    dirty_d[ctrl_q.row] = 1'b0;
                    wear_d[ctrl_q.row]  = wear_next;
                    ctrl_d.state        = ST_SCAN;
                end else begin
                    ctrl_d.timer = ctrl_q.timer - TMR_W'(1);
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mask_q  <= '0;
            dirty_q <= '0;
            for (int a = 0; a < DEPTH; a++) begin
                nvm_q[a]   <= '0;
                sram_q[a]  <= '0;
                stage_q[a] <= '0;
            end
            for (int r = 0; r < ROWS; r++) wear_q[r] <= '0;
        end else begin
            ctrl_q  <= ctrl_d;
            mask_q  <= mask_d;
            dirty_q <= dirty_d;
            nvm_q   <= nvm_d;
            sram_q  <= sram_d;
            stage_q <= stage_d;
            wear_q  <= wear_d;
        end
    end

    assign busy        = (ctrl_q.state == ST_SCAN) || (ctrl_q.state == ST_PROG);
    assign rd_data     = sram_q[rd_addr];
    assign rd_nvm_data = nvm_q[rd_addr];
    assign wear_count  = wear_q[wear_row];

    // R7: no start is acknowledged during programming
    a_r7_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_start_ack);

    // R5: a scratch-only transaction never enters programming
    a_r5_shadow_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_RECV && ctrl_q.shadow && wr_stop) |=> !busy);

    // R2: when idle, no row is left pending
    a_r2_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_IDLE) |-> (dirty_q == '0));

    for (genvar a = 0; a < DEPTH; a++) begin : g_nvm_chk
        // R9: nonvolatile bytes move only on a program cycle
        a_r9_nvm_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
            !commit_now |=> $stable(nvm_q[a]));
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_wear_chk
        // R8: saturated count stays put
        a_r8_wear_saturates: assert property (@(posedge clk) disable iff (!rst_n)
            (wear_q[r] == WEAR_MAX) |=> (wear_q[r] == WEAR_MAX));
        // R4: a count moves by at most one per cycle
        a_r4_wear_single_step: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (wear_q[r] == $past(wear_q[r]) ||
                      wear_q[r] == $past(wear_q[r]) + WEAR_W'(1)));
    end
endmodule

// File: tb/nvm_row_writer_tb.sv
module nvm_row_writer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 8, ROW_BYTES = 8, WEAR_W = 4, BUSY_CYCLES = 4;
    localparam int DEPTH = ROWS * ROW_BYTES;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int ROW_W = $clog2(ROWS);
    localparam int WEAR_MAX = (1 << WEAR_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sram_mode = 1'b0, wr_start = 1'b0, wr_valid = 1'b0, wr_stop = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [ROW_W-1:0] wear_row = '0;
    logic wr_start_ack, busy;
    logic [7:0] rd_data, rd_nvm_data;
    logic [WEAR_W-1:0] wear_count;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    int exp_nvm [DEPTH];
    int exp_sram[DEPTH];
    int exp_wear[ROWS];

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_row_writer #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .WEAR_W(WEAR_W),
                     .BUSY_CYCLES(BUSY_CYCLES)) u_dut (
        .clk(clk), .rst_n(rst_n), .sram_mode(sram_mode), .wr_start(wr_start),
        .wr_addr(wr_addr), .wr_start_ack(wr_start_ack), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_stop(wr_stop), .busy(busy), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_nvm_data(rd_nvm_data), .wear_row(wear_row),
        .wear_count(wear_count));

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic verify_all(string req);
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = ADDR_W'(a);
            #1;
            chk({req, " scratch byte"}, int'(rd_data), exp_sram[a]);
            chk({req, " nvm byte"}, int'(rd_nvm_data), exp_nvm[a]);
        end
        for (int r = 0; r < ROWS; r++) begin
            wear_row = ROW_W'(r);
            #1;
            chk({req, " R4 wear"}, int'(wear_count), exp_wear[r]);
        end
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        while (busy && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic run_txn(string req, int addr, int n, bit shadow, int seed);
        bit touched[ROWS];
        int k = 0, cnt;
        @(negedge clk);
        sram_mode = shadow; wr_addr = ADDR_W'(addr); wr_start = 1'b1;
        #1 chk({req, " R7 ack when idle"}, int'(wr_start_ack), 1);
        @(negedge clk);
        wr_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1; wr_data = 8'((seed + i * 37) & 255);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        rd_addr = ADDR_W'(addr);
        #1 chk({req, " R9 nvm unchanged before stop"}, int'(rd_nvm_data), exp_nvm[addr % DEPTH]);
        wr_stop = 1'b1;
        @(negedge clk);
        wr_stop = 1'b0;
        for (int r = 0; r < ROWS; r++) touched[r] = 0;
        for (int i = 0; i < n; i++) begin
            int a = (addr + i) % DEPTH;
            int d = (seed + i * 37) & 255;
            if (shadow) exp_sram[a] = d;
            else begin
                exp_nvm[a] = d;
                touched[a / ROW_BYTES] = 1;
            end
        end
        for (int r = 0; r < ROWS; r++) if (touched[r]) begin
            k++;
            for (int c = 0; c < ROW_BYTES; c++)
                exp_sram[r*ROW_BYTES + c] = exp_nvm[r*ROW_BYTES + c];
            if (exp_wear[r] < WEAR_MAX) exp_wear[r]++;
        end
        wait_idle(cnt);
        chk({req, " R6 busy cycles"}, cnt, (k == 0) ? 0 : 1 + k * (BUSY_CYCLES + 1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        for (int a = 0; a < DEPTH; a++) begin exp_nvm[a] = 0; exp_sram[a] = 0; end
        for (int r = 0; r < ROWS; r++) exp_wear[r] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 ack", int'(wr_start_ack), 0);
        verify_all("R1");
        // R2 full row, R4 one count
        run_txn("R2", 16, ROW_BYTES, 0, 5);
        verify_all("R2");
        // R3 partial write keeps neighbours
        run_txn("R3", 18, 2, 0, 200);
        verify_all("R3");
        // R5 scratch-only write
        run_txn("R5", 20, 3, 1, 90);
        verify_all("R5");
        // R3 commit refreshes scratch row from merged nvm row
        run_txn("R3", 23, 1, 0, 11);
        verify_all("R3 refresh");
        // R6 crossing two and three rows, and wrap to row 0
        run_txn("R6", 30, 6, 0, 33);
        verify_all("R6 two rows");
        run_txn("R6", 46, 12, 0, 71);
        verify_all("R6 three rows");
        run_txn("R6", 62, 4, 0, 140);
        verify_all("R6 wrap R2");
        // R7 refused transaction while busy
        @(negedge clk);
        sram_mode = 1'b0; wr_addr = ADDR_W'(40); wr_start = 1'b1;
        @(negedge clk);
        wr_start = 1'b0; wr_valid = 1'b1; wr_data = 8'h5C;
        @(negedge clk);
        wr_valid = 1'b0; wr_stop = 1'b1;
        @(negedge clk);
        wr_stop = 1'b0;
        exp_nvm[40] = 8'h5C;
        for (int c = 0; c < ROW_BYTES; c++) exp_sram[40 + c] = exp_nvm[40 + c];
        exp_wear[5]++;
        chk("R7 busy during commit", int'(busy), 1);
        wr_addr = ADDR_W'(56); wr_start = 1'b1;
        #1 chk("R7 refused ack", int'(wr_start_ack), 0);
        @(negedge clk);
        wr_start = 1'b0; wr_valid = 1'b1; wr_data = 8'hAA;
        @(negedge clk);
        wr_valid = 1'b0; wr_stop = 1'b1;
        @(negedge clk);
        wr_stop = 1'b0;
        wait_idle(cnt);
        verify_all("R7");
        // Sweep row 1: every start column and length; drives R8 saturation
        for (int s = 0; s < ROW_BYTES; s++) begin
            for (int len = 1; len <= ROW_BYTES; len++) begin
                run_txn("R3 sweep", ROW_BYTES + s, len, (len == 3) ? 1'b1 : 1'b0, s * 13 + len);
                verify_all("R3 sweep");
            end
        end
        wear_row = ROW_W'(1);
        #1 chk("R8 saturated wear", int'(wear_count), WEAR_MAX);
        run_txn("R8", 9, 1, 0, 3);
        wear_row = ROW_W'(1);
        #1 chk("R8 no wrap", int'(wear_count), WEAR_MAX);
        verify_all("R8");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule